// File: doc/BRIEF.md
# Tiny Stored-Program Digit Sequencer

This block is a very small stored-program machine. It executes a fixed program that makes a 5-bit output register show a sequence of numbers. A 5-bit program counter addresses a 32-word read-only program. Each 7-bit word is decoded into one of four actions:
- jump unconditionally,
- jump when an external condition input is high,
- load a value into the output register,
- add one to the output register.

Each instruction finishes in one clock cycle. The word at the current address is fetched and decoded combinationally, and both the counter and the output register update on the next rising edge.

The stored program first jumps from address 0 to the start address 8. It then shows seven numbers (3, 1, 4, 1, 5, 9, 29), adds one to the last number three times (giving 30, 31 and 0), and jumps back to the start. At the start address a conditional jump tests the condition input. When the input is high, the first three numbers are skipped, so only the last four numbers and the three increments repeat. The current address is driven out beside the number so that the instruction flow can be followed from outside.

Top module: `digit_sequencer`

## Requirements
- R1: Reset is synchronous and active high. On every rising edge where `rst` is 1, both `addr_o` and `digit_o` become 0, and they stay 0 while `rst` remains 1.
- R2: An instruction word has its opcode in bits 6:5 and a 5-bit field in bits 4:0. Opcode 00 loads the field into the program counter on the next edge.
- R3: Opcode 01 loads the field into the program counter when `cond_i` is 1 at the edge. When `cond_i` is 0, the counter moves to the next address.
- R4: Opcode 10 loads the 5-bit field into `digit_o` on the next edge.
- R5: Opcode 11 sets `digit_o` to its previous value plus one, whatever the low five bits of the word hold.
- R6: `digit_o` keeps its value across opcodes 00 and 01, whether or not the jump is taken.
- R7: The program is laid out as follows.
  - Address 0: jump to 8.
  - Address 8: conditional jump to 12.
  - Addresses 9 to 15: load 3, 1, 4, 1, 5, 9, 29, one value per address in that order.
  - Addresses 16, 17 and 18: increment, with fields 00000, 10101 and 11111.
  - Address 19: jump to 8.
  - Every other address: jump to 0.
  - Any instruction other than a taken jump advances the counter by one.
- R8: A pass that leaves address 8 with `cond_i` low takes 12 cycles to return to address 8. A pass that leaves it with `cond_i` high takes 9 cycles.
- R9: Incrementing an output value of 31 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 1 | Condition tested by the conditional jump |
| digit_o | output | 5 | Current value of the output register |
| addr_o | output | 5 | Current program-counter value |

## Verification
The hardest case to reach from the ports is the condition input changing around the one cycle in which the counter sits at address 8. At that address the input decides the whole next pass, and at every other address it must have no effect. To cover this, the bench runs phases with the input held low, held high, and toggled by a bit pattern of the cycle count. In every phase a bench-side model of the program predicts the address and the output one cycle ahead. The increment wrap from 31 to 0 is reached on every pass, and a reset is applied in the middle of a run while the output is nonzero.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Widths of the machine
    localparam int PC_W    = 5;
    localparam int FIELD_W = 5;
    localparam int OPC_W   = 2;
    localparam int INSTR_W = OPC_W + FIELD_W;

    // Program labels
    localparam logic [PC_W-1:0] START_LBL = PC_W'(8);
    localparam logic [PC_W-1:0] LOOP_LBL  = PC_W'(12);
    localparam logic [PC_W-1:0] RESET_LBL = PC_W'(0);

    typedef enum logic [OPC_W-1:0] {
        OPC_JMP = 2'b00,
        OPC_JC  = 2'b01,
        OPC_OUT = 2'b10,
        OPC_INC = 2'b11
    } opcode_e;

    typedef struct packed {
        opcode_e              op;
        logic [FIELD_W-1:0]   field;
    } instr_t;

    typedef struct packed {
        logic pc_load;
        logic out_load;
        logic out_inc;
    } ctrl_t;

    function automatic instr_t mk(opcode_e op, logic [FIELD_W-1:0] f);
        instr_t w;
        w.op    = op;
        w.field = f;
        return w;
    endfunction

    // Fixed program, one word per address
    function automatic instr_t program_word(logic [PC_W-1:0] a);
        instr_t w;
        case (a)
            5'd0:    w = mk(OPC_JMP, START_LBL);
            5'd8:    w = mk(OPC_JC,  LOOP_LBL);
            5'd9:    w = mk(OPC_OUT, 5'd3);
            5'd10:   w = mk(OPC_OUT, 5'd1);
            5'd11:   w = mk(OPC_OUT, 5'd4);
            5'd12:   w = mk(OPC_OUT, 5'd1);
            5'd13:   w = mk(OPC_OUT, 5'd5);
            5'd14:   w = mk(OPC_OUT, 5'd9);
            5'd15:   w = mk(OPC_OUT, 5'd29);
            5'd16:   w = mk(OPC_INC, 5'b00000);
            5'd17:   w = mk(OPC_INC, 5'b10101);
            5'd18:   w = mk(OPC_INC, 5'b11111);
            5'd19:   w = mk(OPC_JMP, START_LBL);
            default: w = mk(OPC_JMP, RESET_LBL);
        endcase
        return w;
    endfunction

    // Control decode straight from the opcode bits
    function automatic ctrl_t decode(instr_t w, logic cond);
        ctrl_t c;
        c.out_load = w.op[1] & ~w.op[0];
        c.out_inc  = w.op[1] &  w.op[0];
        c.pc_load  = (w.op == OPC_JMP) | ((w.op == OPC_JC) & cond);
        return c;
    endfunction

endpackage

// File: rtl/seq_prog_rom.sv
module seq_prog_rom
    import seq_pkg::*;
#(
    parameter int ADDR_W = PC_W
) (
    input  logic [ADDR_W-1:0] addr,
    output instr_t            word
);
    logic [PC_W-1:0] a_int;

    generate
        if (ADDR_W >= PC_W) begin : g_trunc
            assign a_int = addr[PC_W-1:0];
        end else begin : g_ext
            assign a_int = {{(PC_W-ADDR_W){1'b0}}, addr};
        end
    endgenerate

    always_comb begin
        word = program_word(a_int);
    end
endmodule

// File: rtl/seq_decoder.sv
module seq_decoder
    import seq_pkg::*;
(
    input  instr_t word,
    input  logic   cond,
    output ctrl_t  ctrl
);
    always_comb begin
        ctrl = decode(word, cond);
    end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] target,
    output logic [W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (load) pc <= target;
        else           pc <= pc + W'(1);
    end
endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         inc,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
        else if (inc)  q <= q + W'(1);
    end
endmodule

// File: rtl/digit_sequencer.sv
module digit_sequencer
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cond_i,
    output logic [FIELD_W-1:0] digit_o,
    output logic [PC_W-1:0]    addr_o
);
    logic [PC_W-1:0]    pc;
    logic [FIELD_W-1:0] val;
    instr_t             word;
    ctrl_t              ctrl;

    seq_prog_rom #(.ADDR_W(PC_W)) u_rom (
        .addr (pc),
        .word (word)
    );

    seq_decoder u_dec (
        .word (word),
        .cond (cond_i),
        .ctrl (ctrl)
    );

    seq_pc #(.W(PC_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .load   (ctrl.pc_load),
        .target (word.field),
        .pc     (pc)
    );

    seq_out_reg #(.W(FIELD_W)) u_out (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl.out_load),
        .inc  (ctrl.out_inc),
        .din  (word.field),
        .q    (val)
    );

    assign digit_o = val;
    assign addr_o  = pc;
endmodule

// File: rtl/seq_check.sv
module seq_check
    import seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cond_i,
    input logic [PC_W-1:0]    addr,
    input logic [FIELD_W-1:0] digit,
    input ctrl_t              ctrl
);
    logic [FIELD_W-1:0] digit_plus;
    assign digit_plus = digit + FIELD_W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (addr == '0 && digit == '0));

    // R2
    start_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 5'd0) |=> (addr == 5'd8));

    // R3
    jc_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 5'd8 && cond_i) |=> (addr == 5'd12));

    // R3
    jc_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 5'd8 && !cond_i) |=> (addr == 5'd9));

    // R4
    load_val_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 5'd15) |=> (digit == 5'd29));

    // R5
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.out_inc |=> (digit == $past(digit_plus)));

    // R6
    jump_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 5'd0 || addr == 5'd8 || addr == 5'd19) |=> $stable(digit));

    // R9
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.out_inc && digit == 5'd31) |=> (digit == 5'd0));
endmodule

bind digit_sequencer seq_check u_chk (
    .clk    (clk),
    .rst    (rst),
    .cond_i (cond_i),
    .addr   (addr_o),
    .digit  (digit_o),
    .ctrl   (ctrl)
);

// File: tb/sim_digit_sequencer.sv
`timescale 1ns/1ps
module sim_digit_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cond = 1'b0;
    logic [4:0] digit;
    logic [4:0] addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [4:0] exp_addr;
    logic [4:0] exp_dig;
    string      atag;
    string      dtag;
    int         lap_cnt;
    bit         lap_valid;
    logic       lap_cond;
    int         cyc = 0;

    always #2.5 clk = ~clk;

    digit_sequencer u0 (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (cond),
        .digit_o (digit),
        .addr_o  (addr)
    );

    task automatic chk(string tag, string what, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_int(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Values loaded at addresses 9..15 (R7)
    function automatic logic [4:0] out_val(logic [4:0] a);
        case (a)
            5'd9:    return 5'd3;
            5'd10:   return 5'd1;
            5'd11:   return 5'd4;
            5'd12:   return 5'd1;
            5'd13:   return 5'd5;
            5'd14:   return 5'd9;
            default: return 5'd29;
        endcase
    endfunction

    // Predicts the state after one edge from the program listing
    task automatic model_step(logic c);
        if (exp_addr == 5'd0 || exp_addr == 5'd19) begin
            atag = "R2"; dtag = "R6";
            exp_addr = 5'd8;
        end else if (exp_addr == 5'd8) begin
            atag = "R3"; dtag = "R6";
            exp_addr = c ? 5'd12 : 5'd9;
        end else if (exp_addr >= 5'd9 && exp_addr <= 5'd15) begin
            atag = "R7"; dtag = "R4";
            exp_dig = out_val(exp_addr);
            exp_addr = exp_addr + 5'd1;
        end else if (exp_addr >= 5'd16 && exp_addr <= 5'd18) begin
            atag = "R7";
            dtag = (exp_dig == 5'd31) ? "R9" : "R5";
            exp_dig = exp_dig + 5'd1;
            exp_addr = exp_addr + 5'd1;
        end else begin
            atag = "R7"; dtag = "R6";
            exp_addr = 5'd0;
        end
    endtask

    // mode 0: cond low, 1: cond high, 2: cond from a cycle-count pattern
    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            chk(atag, "addr", addr, exp_addr);
            chk(dtag, "digit", digit, exp_dig);
            case (mode)
                0:       cond = 1'b0;
                1:       cond = 1'b1;
                default: cond = cyc[1] ^ cyc[3] ^ cyc[4];
            endcase
            if (exp_addr == 5'd8) begin
                if (lap_valid)
                    chk_int("R8", "lap length", lap_cnt, lap_cond ? 9 : 12);
                lap_valid = 1;
                lap_cnt   = 0;
                lap_cond  = cond;
            end
            lap_cnt++;
            cyc++;
            model_step(cond);
            @(negedge clk);
        end
    endtask

    task automatic apply_reset(int n);
        rst = 1'b1;
        lap_valid = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R1", "addr in reset", addr, 5'd0);
            chk("R1", "digit in reset", digit, 5'd0);
        end
        rst = 1'b0;
        exp_addr = 5'd0;
        exp_dig  = 5'd0;
        atag = "R1"; dtag = "R1";
    endtask

    initial begin
        lap_valid = 0;
        lap_cnt = 0;
        lap_cond = 1'b0;
        // R1: reset state
        apply_reset(3);
        // First pass with cond low: full sequence, increments, wrap (R4 R5 R9 R7)
        run(13, 0);
        // Condition high: only the last four values repeat (R3 R8)
        run(40, 1);
        // Condition toggling at arbitrary cycles: only address 8 reacts (R3 R6)
        run(300, 2);
        // Back to low: full passes again
        run(30, 0);
        // R1: reset in the middle of a run, then restart
        run(7, 0);
        apply_reset(2);
        run(25, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule